// File: doc/BRIEF.md
# Multi-Pipe Descriptor Fetch Arbiter With Group Locking

This block decides which of several DMA pipes that share one peripheral may fetch its next descriptor. Each pipe keeps a count of descriptors that software has announced through events. A group number is configured for each pipe. The arbiter issues one fetch request at a time over a valid/ready handshake. It then waits for the fetched descriptor to come back, and looks at that descriptor's type bit and flags before it issues the next request.

A command-type descriptor that carries the lock flag makes the arbiter exclusive to the group of the pipe that fetched it. Pipes outside that group are not requested while the lock holds, but events still raise their counts. When the owning pipe later returns a command descriptor with the unlock flag, all pipes compete again in round-robin order. The backlog that built up during the lock is then served in full. Flags on data descriptors are ignored. The block reports whether a lock is active and which pipe owns it.

Top module: `pipe_fetch_arbiter`

## Requirements
- R1: While rst_n is low at a clock edge, the request, the lock and all pending counts clear and the round-robin pointer returns to pipe 0. After reset, req_valid, lock_active and lock_owner read 0, and no request appears until an event adds work.
- R2: An event cycle adds evt_num to the pending count of every pipe set in evt_mask. A count saturates at 2^CNT_W-1. A pipe with count c receives exactly c fetch handshakes, and each handshake consumes one.
- R3: Among the eligible pipes with a nonzero count, the next request goes to the first one found when searching upward, with wrap-around, from the pipe after the last granted one. Pipe 0 is searched first after reset.
- R4: req_valid stays high with req_pipe stable until req_ready is sampled high. Only one fetch is outstanding at a time. No new request is raised until desc_valid returns the descriptor for the granted pipe.
- R5: A returned descriptor with desc_cmd=1 and flag bit 8 (lock) set, and bit 9 clear, sets lock_active on the following cycle while no lock is held. lock_owner becomes the granted pipe.
- R6: While the lock is held, only pipes whose pipe_group field equals the owner's are requested. Events to other pipes still raise their counts.
- R7: A command descriptor with flag bit 9 (unlock) returned from the owner pipe clears lock_active. After that, all pipes are again eligible, including every accumulated descriptor.
- R8: A data descriptor (desc_cmd=0) never changes the lock state, whatever its flags hold.
- R9: While a lock is held, a lock flag does not nest or move ownership, and an unlock flag from a pipe other than the owner is ignored.
- R10: A command descriptor with both bits 8 and 9 set leaves no lock behind once it has been consumed. When no lock is held, all pipes stay eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_mask | input | NUM_PIPES | Pipes that receive new descriptors this cycle |
| evt_num | input | CNT_W | Number of descriptors added to each pipe in evt_mask |
| pipe_group | input | NUM_PIPES*GRP_W | Group number of each pipe; pipe i uses bits [i*GRP_W +: GRP_W] |
| req_valid | output | 1 | Fetch request valid |
| req_pipe | output | PIPE_W | Pipe whose descriptor is to be fetched |
| req_ready | input | 1 | Fetch request accepted |
| desc_valid | input | 1 | Fetched descriptor is presented |
| desc_cmd | input | 1 | Descriptor is a command descriptor |
| desc_flags | input | FLAG_W | Descriptor flags; bit 8 lock, bit 9 unlock |
| lock_active | output | 1 | A group lock is held |
| lock_owner | output | PIPE_W | Pipe that owns the lock |

## Verification
The hardest situation to reach from the ports is a held lock during which descriptors arrive both for the owner's group and for starved pipes. In that window, lock and unlock flags also come from a group member that is not the owner. The owner's group must then run dry so the arbiter sits idle with work still pending elsewhere. Directed sequences build this state step by step, with events injected while a fetch is outstanding. A seeded random phase then mixes command and data descriptors with random flag bits and event masks. A bench model predicts every grant and every lock transition.

// File: rtl/pipe_arb_pkg.sv
// Shared types for the pipe fetch arbiter.
package pipe_arb_pkg;
    // Fetch sequencing: pick a pipe, hold the request, await the descriptor.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } arb_state_t;
endpackage

// File: rtl/pend_bank.sv
// Per-pipe pending descriptor counters.
// Adds evt_num to every pipe in evt_mask, subtracts one from the granted pipe,
// and saturates at the counter maximum. Assumes a decrement is only requested
// for a pipe whose count is nonzero.
module pend_bank #(
    parameter int NUM_PIPES = 4,
    parameter int CNT_W     = 4,
    localparam int PIPE_W   = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PIPES-1:0]             evt_mask,
    input  logic [CNT_W-1:0]                 evt_num,
    input  logic                             dec_en,
    input  logic [PIPE_W-1:0]                dec_pipe,
    output logic [NUM_PIPES-1:0][CNT_W-1:0]  pend,
    output logic [NUM_PIPES-1:0]             pend_nz
);
    localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

    for (genvar i = 0; i < NUM_PIPES; i++) begin : g_pipe
        logic [CNT_W:0] sum;
        logic           dec_here;

        // Next count: current minus grant plus event amount, before saturation.
        always_comb begin
            dec_here = dec_en && (dec_pipe == PIPE_W'(i));
            sum = {1'b0, pend[i]} - {{CNT_W{1'b0}}, dec_here}
                + (evt_mask[i] ? {1'b0, evt_num} : '0);
        end

        // Register the saturated count.
        always_ff @(posedge clk) begin
            if (!rst_n)              pend[i] <= '0;
            else if (sum > CNT_MAX)  pend[i] <= CNT_MAX[CNT_W-1:0];
            else                     pend[i] <= sum[CNT_W-1:0];
        end

        assign pend_nz[i] = (pend[i] != '0);

        AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[i] == CNT_MAX[CNT_W-1:0]) && !dec_here |=> pend[i] == CNT_MAX[CNT_W-1:0]); // R2
        AST_DEC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
            dec_here |-> pend[i] != '0); // R2
    end
endmodule

// File: rtl/group_lock.sv
// Group lock state.
// Inspects each consumed descriptor: a command descriptor with the lock flag
// (and no unlock flag) takes the lock for the granted pipe when none is held;
// a command descriptor with the unlock flag from the owner releases it.
// Produces the per-pipe eligibility mask. Assumes desc_fire marks exactly one
// consumed descriptor that belongs to cur_pipe.
module group_lock #(
    parameter int NUM_PIPES  = 4,
    parameter int GRP_W      = 2,
    parameter int FLAG_W     = 16,
    parameter int LOCK_BIT   = 8,
    parameter int UNLOCK_BIT = 9,
    localparam int PIPE_W    = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       desc_fire,
    input  logic                       desc_cmd,
    input  logic [FLAG_W-1:0]          desc_flags,
    input  logic [PIPE_W-1:0]          cur_pipe,
    input  logic [NUM_PIPES*GRP_W-1:0] pipe_group,
    output logic                       lock_active,
    output logic [PIPE_W-1:0]          lock_owner,
    output logic [NUM_PIPES-1:0]       elig
);
    logic             want_lock;
    logic             want_unlock;
    logic [GRP_W-1:0] owner_grp;

    assign want_lock   = desc_fire && desc_cmd && desc_flags[LOCK_BIT] && !desc_flags[UNLOCK_BIT];
    assign want_unlock = desc_fire && desc_cmd && desc_flags[UNLOCK_BIT];
    assign owner_grp   = pipe_group[lock_owner*GRP_W +: GRP_W];

    // Take the lock when free; release only on the owner's unlock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_active <= 1'b0;
            lock_owner  <= '0;
        end else if (!lock_active && want_lock) begin
            lock_active <= 1'b1;
            lock_owner  <= cur_pipe;
        end else if (lock_active && want_unlock && (cur_pipe == lock_owner)) begin
            lock_active <= 1'b0;
        end
    end

    for (genvar i = 0; i < NUM_PIPES; i++) begin : g_elig
        // A pipe is eligible when unlocked or in the owner's group.
        assign elig[i] = !lock_active || (pipe_group[i*GRP_W +: GRP_W] == owner_grp);
    end

    AST_RELEASE_BY_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_active) |-> $past(desc_fire && desc_cmd && desc_flags[UNLOCK_BIT]
                                     && (cur_pipe == lock_owner))); // R7
    AST_DATA_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        desc_fire && !desc_cmd |=> $stable(lock_active) && $stable(lock_owner)); // R8
    AST_OWNER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        lock_active && $past(lock_active) |-> $stable(lock_owner)); // R9
endmodule

// File: rtl/rr_fetch_sched.sv
// Round-robin fetch sequencer.
// Picks the next candidate pipe starting after the last granted one, holds
// the request until accepted, then waits for the descriptor before picking
// again. Assumes cand only changes through counts and lock state.
module rr_fetch_sched #(
    parameter int NUM_PIPES = 4,
    localparam int PIPE_W   = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PIPES-1:0]  cand,
    input  logic                  req_ready,
    input  logic                  desc_valid,
    output logic                  req_valid,
    output logic [PIPE_W-1:0]     req_pipe,
    output logic                  grant_fire,
    output logic                  desc_fire
);
    import pipe_arb_pkg::*;

    arb_state_t        state;
    logic [PIPE_W-1:0] ptr;
    logic [PIPE_W-1:0] pick;
    logic              found;

    // Rotating-priority search starting at ptr.
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int k = 0; k < NUM_PIPES; k++) begin
            int idx;
            idx = (int'(ptr) + k) % NUM_PIPES;
            if (!found && cand[idx]) begin
                found = 1'b1;
                pick  = PIPE_W'(idx);
            end
        end
    end

    assign req_valid  = (state == ST_REQ);
    assign grant_fire = (state == ST_REQ) && req_ready;
    assign desc_fire  = (state == ST_WAIT) && desc_valid;

    // Sequence one fetch at a time and advance the pointer on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ptr      <= '0;
            req_pipe <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (found) begin
                    state    <= ST_REQ;
                    req_pipe <= pick;
                end
                ST_REQ:  if (req_ready) state <= ST_WAIT;
                ST_WAIT: if (desc_valid) begin
                    state <= ST_IDLE;
                    ptr   <= (req_pipe == PIPE_W'(NUM_PIPES-1)) ? '0 : req_pipe + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_pipe)); // R4
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        grant_fire |=> !req_valid); // R4
endmodule

// File: rtl/pipe_fetch_arbiter.sv
// Top level: descriptor fetch arbiter for pipes sharing one peripheral.
// Combines the pending counters, the group lock and the round-robin sequencer.
// Assumes one descriptor returns per accepted request, in order.
module pipe_fetch_arbiter #(
    parameter int NUM_PIPES  = 4,
    parameter int CNT_W      = 4,
    parameter int GRP_W      = 2,
    parameter int FLAG_W     = 16,
    parameter int LOCK_BIT   = 8,
    parameter int UNLOCK_BIT = 9,
    localparam int PIPE_W    = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PIPES-1:0]       evt_mask,
    input  logic [CNT_W-1:0]           evt_num,
    input  logic [NUM_PIPES*GRP_W-1:0] pipe_group,
    output logic                       req_valid,
    output logic [PIPE_W-1:0]          req_pipe,
    input  logic                       req_ready,
    input  logic                       desc_valid,
    input  logic                       desc_cmd,
    input  logic [FLAG_W-1:0]          desc_flags,
    output logic                       lock_active,
    output logic [PIPE_W-1:0]          lock_owner
);
    logic [NUM_PIPES-1:0][CNT_W-1:0] pend;
    logic [NUM_PIPES-1:0]            pend_nz;
    logic [NUM_PIPES-1:0]            elig;
    logic                            grant_fire;
    logic                            desc_fire;

    pend_bank #(.NUM_PIPES(NUM_PIPES), .CNT_W(CNT_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_mask (evt_mask),
        .evt_num  (evt_num),
        .dec_en   (grant_fire),
        .dec_pipe (req_pipe),
        .pend     (pend),
        .pend_nz  (pend_nz)
    );

    group_lock #(
        .NUM_PIPES(NUM_PIPES), .GRP_W(GRP_W), .FLAG_W(FLAG_W),
        .LOCK_BIT(LOCK_BIT), .UNLOCK_BIT(UNLOCK_BIT)
    ) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .desc_fire   (desc_fire),
        .desc_cmd    (desc_cmd),
        .desc_flags  (desc_flags),
        .cur_pipe    (req_pipe),
        .pipe_group  (pipe_group),
        .lock_active (lock_active),
        .lock_owner  (lock_owner),
        .elig        (elig)
    );

    rr_fetch_sched #(.NUM_PIPES(NUM_PIPES)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand       (pend_nz & elig),
        .req_ready  (req_ready),
        .desc_valid (desc_valid),
        .req_valid  (req_valid),
        .req_pipe   (req_pipe),
        .grant_fire (grant_fire),
        .desc_fire  (desc_fire)
    );

    AST_GRANT_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> pend[req_pipe] != '0); // R2
    AST_LOCKED_GROUP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_active && req_valid |->
            pipe_group[req_pipe*GRP_W +: GRP_W] == pipe_group[lock_owner*GRP_W +: GRP_W]); // R6
endmodule

// File: tb/pipe_fetch_arbiter_bench.sv
module pipe_fetch_arbiter_bench;
    localparam int N = 4;
    localparam int CW = 4;
    localparam int CMAX = 15;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   evt_mask = '0;
    logic [3:0]   evt_num = '0;
    logic [7:0]   pipe_group = 8'b01_01_00_00;
    logic         req_valid;
    logic [1:0]   req_pipe;
    logic         req_ready = 1'b0;
    logic         desc_valid = 1'b0;
    logic         desc_cmd = 1'b0;
    logic [15:0]  desc_flags = '0;
    logic         lock_active;
    logic [1:0]   lock_owner;

    int nchk = 0;
    int nerr = 0;
    int m_pend[N];
    int m_ptr = 0;
    bit m_lock = 0;
    int m_owner = 0;
    int grp[N] = '{0, 0, 1, 1};
    int cyc = 0;

    always #2.5 clk = ~clk;

    pipe_fetch_arbiter u_pipe_fetch_arbiter (
        .clk(clk), .rst_n(rst_n), .evt_mask(evt_mask), .evt_num(evt_num),
        .pipe_group(pipe_group), .req_valid(req_valid), .req_pipe(req_pipe),
        .req_ready(req_ready), .desc_valid(desc_valid), .desc_cmd(desc_cmd),
        .desc_flags(desc_flags), .lock_active(lock_active), .lock_owner(lock_owner)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_pick();
        for (int k = 0; k < N; k++) begin
            int i;
            i = (m_ptr + k) % N;
            if (m_pend[i] > 0 && (!m_lock || grp[i] == grp[m_owner])) return i;
        end
        return -1;
    endfunction

    function automatic void model_add(input int mask, input int num);
        for (int i = 0; i < N; i++)
            if (mask[i]) m_pend[i] = (m_pend[i] + num > CMAX) ? CMAX : m_pend[i] + num;
    endfunction

    function automatic void model_desc(input int p, input bit cmd, input int flags);
        bit lk, ul;
        lk = flags[8];
        ul = flags[9];
        if (cmd) begin
            if (!m_lock && lk && !ul) begin
                m_lock = 1;
                m_owner = p;
            end else if (m_lock && ul && p == m_owner) begin
                m_lock = 0;
            end
        end
        m_ptr = (p + 1) % N;
    endfunction

    task automatic inject(input int mask, input int num);
        evt_mask = mask[3:0];
        evt_num = num[3:0];
        @(negedge clk);
        evt_mask = '0;
        evt_num = '0;
        model_add(mask, num);
    endtask

    task automatic check_idle(input int n, input string req);
        repeat (n) begin
            @(negedge clk);
            chk(!req_valid, req, int'(req_valid), 0);
        end
    endtask

    // One full fetch: request, random stall, handshake, optional events, descriptor.
    task automatic fetch(input bit cmd, input int flags, input int emask, input int enm,
                         output int got);
        int e, t, stall;
        e = exp_pick();
        t = 0;
        while (!req_valid && t < 200) begin
            @(negedge clk);
            t++;
        end
        got = -1;
        if (!req_valid) begin
            chk(0, "R3 no request", 0, e);
            return;
        end
        got = int'(req_pipe);
        chk(got == e, "R3 pick", got, e);
        if (m_lock) chk(grp[got] == grp[m_owner], "R6 group", grp[got], grp[m_owner]);
        stall = $urandom % 3;
        repeat (stall) begin
            @(negedge clk);
            chk(req_valid && int'(req_pipe) == got, "R4 hold", int'(req_pipe), got);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        m_pend[got]--;
        chk(!req_valid, "R4 single outstanding", int'(req_valid), 0);
        if (emask != 0) inject(emask, enm);
        else @(negedge clk);
        chk(!req_valid, "R4 wait for descriptor", int'(req_valid), 0);
        desc_valid = 1'b1;
        desc_cmd = cmd;
        desc_flags = flags[15:0];
        @(negedge clk);
        desc_valid = 1'b0;
        desc_cmd = 1'b0;
        desc_flags = '0;
        model_desc(got, cmd, flags);
        chk(lock_active == m_lock, "R5 lock state", int'(lock_active), int'(m_lock));
        if (m_lock) chk(int'(lock_owner) == m_owner, "R5 owner", int'(lock_owner), m_owner);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                nerr++;
                $display("FAIL watchdog R4 actual=%0d expected=%0d", cyc, 150000);
                $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
                $finish;
            end
        end
    end

    initial begin
        int p;
        void'($urandom(32'd20210201));
        for (int i = 0; i < N; i++) m_pend[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!req_valid, "R1 req_valid", int'(req_valid), 0);
        chk(!lock_active, "R1 lock_active", int'(lock_active), 0);
        chk(lock_owner == 0, "R1 lock_owner", int'(lock_owner), 0);
        check_idle(4, "R1 idle");

        // R3: order 0,1,2,3 from reset
        inject(4'b1111, 1);
        for (int k = 0; k < 4; k++) begin
            fetch(0, 0, 0, 0, p);
            chk(p == k, "R3 order", p, k);
        end

        // R8: data descriptor with lock flag does nothing
        inject(4'b1111, 2);
        fetch(0, 16'h0100, 0, 0, p);
        chk(!lock_active, "R8 data lock ignored", int'(lock_active), 0);
        // R5: command lock from pipe 1
        fetch(1, 16'h0100, 0, 0, p);
        chk(lock_active && lock_owner == 1, "R5 lock taken", int'(lock_owner), 1);
        // R6: starved pipes accumulate
        inject(4'b1100, 3);
        fetch(1, 16'h0100, 0, 0, p);
        chk(p == 0 && lock_owner == 1, "R9 no nested lock", int'(lock_owner), 1);
        fetch(0, 0, 0, 0, p);
        check_idle(5, "R6 starved pipes idle");
        inject(4'b0011, 1);
        fetch(1, 16'h0200, 0, 0, p);
        chk(p == 0 && lock_active, "R9 non-owner unlock ignored", int'(lock_active), 1);
        fetch(1, 16'h0200, 0, 0, p);
        chk(p == 1 && !lock_active, "R7 owner unlock", int'(lock_active), 0);
        for (int k = 0; k < 10; k++) fetch(0, 0, 0, 0, p);
        check_idle(4, "R7 backlog fully served");

        // R10: both flags leave no lock
        inject(4'b0001, 2);
        fetch(1, 16'h0300, 4'b0100, 1, p);
        chk(!lock_active, "R10 both flags", int'(lock_active), 0);
        fetch(0, 0, 0, 0, p);
        chk(p == 2, "R10 other group served", p, 2);
        fetch(0, 0, 0, 0, p);
        check_idle(3, "R10 drained");

        // R2: saturation at 15
        inject(4'b1000, 15);
        inject(4'b1000, 15);
        for (int k = 0; k < 15; k++) begin
            fetch(0, 0, 0, 0, p);
            chk(p == 3, "R2 saturated pipe", p, 3);
        end
        check_idle(5, "R2 saturation limit");

        // Random phase
        for (int it = 0; it < 400; it++) begin
            bit cmd;
            int f, em;
            while (exp_pick() < 0) inject(($urandom % 15) + 1, ($urandom % 3) + 1);
            cmd = ($urandom % 3) == 0;
            f = $urandom & 16'hFCFF;
            if ($urandom % 4 == 0) f |= 16'h0100;
            if ($urandom % 4 == 0) f |= 16'h0200;
            em = ($urandom % 2 == 0) ? int'($urandom % 16) : 0;
            fetch(cmd, f, em, ($urandom % 3) + 1, p);
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule